// File: doc/BRIEF.md
# Stop-Mode Entry and Wakeup Sequencer

This block decides when the processor core may drop into a deep stop state and when it has to come back. The core raises a one-cycle request when it executes a wait-for-interrupt or a wait-for-event instruction, or when it returns from a handler. The block qualifies that request against three things:

- the deep-sleep, sleep-on-exit and send-event-on-pending control bits;
- a 3-bit mode select;
- the current pending state of the external lines and of the peripheral wakeup flag.

Depending on the result, the block either ignores the request, parks the core in a plain sleep with clocks running, or enters one of two stop states.

The request path taken at entry is stored in a register. Until the core is running again, that register alone decides which lines are allowed to wake it. Three values are possible:

- enabled interrupt lines;
- event lines;
- every interrupt line, whether or not its vector is enabled.

The deeper stop state runs from the low-power regulator. It is entered only once that regulator reports ready.

On wakeup from a stop state, the block loads three programmable latencies into down-counters: oscillator restart, regulator restart and flash restart. It holds the core halted for the longer of the first two plus the third. When the core is released, it emits a one-cycle wake pulse. All control and status pins are plain levels or single-cycle pulses. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `lpstop_ctrl`

## Requirements
- R1: After reset the core runs: core_halt=0, clk_run=1, lp_reg_sel=0, wake_pulse=0.
- R2: A wait-for-interrupt or wait-for-event request with deep_sleep=1 and mode_sel=3'b001 enters the first stop state one cycle later: core_halt=1, clk_run=0, lp_reg_sel=0.
- R3: A return-from-handler request leads to a halt only when sleep_on_exit=1. With sleep_on_exit=0 it is ignored and core_halt stays 0.
- R4: If any bit of line_pend or periph_flag is 1 in the cycle of a request, the request is ignored and core_halt stays 0.
- R5: With mode_sel=3'b010, entry waits while reg_ready=0, with core_halt=1, clk_run=1 and lp_reg_sel=0. The cycle after reg_ready is seen high, clk_run=0 and lp_reg_sel=1. A wake source seen while waiting returns the core to run at once.
- R6: After a wait-for-interrupt or return-from-handler entry, only a pending line with line_is_irq=1 (interrupt mode) and line_vec_en=1 wakes the core. Event-mode lines (line_is_irq=0) and interrupt lines with a disabled vector do not.
- R7: After a wait-for-event entry with sev_on_pend=0, only pending event-mode lines (line_is_irq=0) wake the core.
- R8: After a wait-for-event entry with sev_on_pend=1, any pending interrupt-mode line wakes the core regardless of line_vec_en. Event-mode lines do not.
- R9: Once a stop state samples a wake source, core_halt stays 1 and clk_run stays 0 for max(osc_wake_cyc, reg_wake_cyc) + flash_wake_cyc + 1 further cycles, then both change together.
- R10: wake_pulse is 1 for exactly the first cycle in which core_halt is 0 after a halt.
- R11: A request with deep_sleep=0, or with a mode_sel other than 3'b001 and 3'b010, gives a plain sleep (core_halt=1, clk_run=1). It ends in the cycle after a wake source is seen, with no latency count.
- R12: The wake-source selection is fixed at entry. Changing sev_on_pend while halted does not change which lines wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wfi | input | 1 | One-cycle wait-for-interrupt request |
| req_wfe | input | 1 | One-cycle wait-for-event request |
| req_ret | input | 1 | One-cycle return-from-handler request |
| deep_sleep | input | 1 | Deep-sleep control bit |
| sleep_on_exit | input | 1 | Allow entry on handler return |
| sev_on_pend | input | 1 | Pending interrupts count as events |
| mode_sel | input | 3 | 001 first stop state, 010 deeper stop state, others plain sleep |
| line_pend | input | LINES | Per-line pending bits |
| line_is_irq | input | LINES | 1 = line in interrupt mode, 0 = event mode |
| line_vec_en | input | LINES | Per-line interrupt-controller vector enable |
| periph_flag | input | 1 | Peripheral wakeup flag pending |
| reg_ready | input | 1 | Low-power regulator ready |
| osc_wake_cyc | input | CNT_W | Oscillator restart cycles |
| reg_wake_cyc | input | CNT_W | Regulator restart cycles |
| flash_wake_cyc | input | CNT_W | Flash restart cycles |
| clk_run | output | 1 | Clock-gate enable, 1 = clocks running |
| lp_reg_sel | output | 1 | Low-power regulator selected |
| core_halt | output | 1 | Core held halted |
| wake_pulse | output | 1 | One-cycle pulse on release |

## Verification
The bench builds the block with LINES=4 and CNT_W=6. Four lines are enough to hold three kinds of line at once:

- an enabled interrupt line;
- an interrupt line with its vector disabled;
- an event line.

With all three present, every entry path shows one line that wakes the core next to lines that must not. The narrow counters keep latencies short, so the bench can compare the halt length cycle by cycle for both an oscillator-dominated and a regulator-dominated wake, and also for the all-zero latency corner.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;
  localparam logic [2:0] MODE_STOP1 = 3'b001;
  localparam logic [2:0] MODE_STOP2 = 3'b010;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_WAIT_REG,
    ST_STOP,
    ST_WAKE
  } lp_state_e;

  typedef enum logic [1:0] {
    PATH_INT,
    PATH_EVT,
    PATH_EVT_SEV
  } lp_path_e;

  typedef enum logic [1:0] {
    KIND_SLEEP,
    KIND_STOP1,
    KIND_STOP2
  } lp_kind_e;
endpackage

// File: rtl/lpstop_entry.sv
module lpstop_entry
  import lpstop_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             req_wfi,
  input  logic             req_wfe,
  input  logic             req_ret,
  input  logic             deep_sleep,
  input  logic             sleep_on_exit,
  input  logic             sev_on_pend,
  input  logic [2:0]       mode_sel,
  input  logic [LINES-1:0] line_pend,
  input  logic             periph_flag,
  output logic             take,
  output lp_kind_e         kind,
  output lp_path_e         path
);
  logic int_req;
  logic any_req;
  logic blocked;

  assign int_req = req_wfi | (req_ret & sleep_on_exit);
  assign any_req = int_req | req_wfe;
  assign blocked = (|line_pend) | periph_flag;
  assign take    = any_req & ~blocked;

  always_comb begin
    if (int_req)          path = PATH_INT;
    else if (sev_on_pend) path = PATH_EVT_SEV;
    else                  path = PATH_EVT;
  end

  always_comb begin
    if (!deep_sleep)                 kind = KIND_SLEEP;
    else if (mode_sel == MODE_STOP1) kind = KIND_STOP1;
    else if (mode_sel == MODE_STOP2) kind = KIND_STOP2;
    else                             kind = KIND_SLEEP;
  end
endmodule

// File: rtl/lpstop_wake.sv
module lpstop_wake
  import lpstop_pkg::*;
#(
  parameter int LINES = 8
) (
  input  lp_path_e         path,
  input  logic [LINES-1:0] line_pend,
  input  logic [LINES-1:0] line_is_irq,
  input  logic [LINES-1:0] line_vec_en,
  output logic             hit
);
  logic [LINES-1:0] line_hit;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_comb begin
      unique case (path)
        PATH_INT:     line_hit[g] = line_pend[g] & line_is_irq[g] & line_vec_en[g];
        PATH_EVT:     line_hit[g] = line_pend[g] & ~line_is_irq[g];
        PATH_EVT_SEV: line_hit[g] = line_pend[g] & line_is_irq[g];
        default:      line_hit[g] = 1'b0;
      endcase
    end
  end

  assign hit = |line_hit;
endmodule

// File: rtl/lpstop_lat.sv
module lpstop_lat #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] osc_cyc,
  input  logic [CNT_W-1:0] reg_cyc,
  input  logic [CNT_W-1:0] flash_cyc,
  output logic             done
);
  localparam int PAR = 2;

  logic [CNT_W-1:0] par_init [PAR];
  logic [CNT_W-1:0] par_q    [PAR];
  logic [PAR-1:0]   par_busy;
  logic [CNT_W-1:0] fl_q;

  assign par_init[0] = osc_cyc;
  assign par_init[1] = reg_cyc;

  for (genvar g = 0; g < PAR; g++) begin : g_par
    assign par_busy[g] = (par_q[g] != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    par_q[g] <= '0;
      else if (load)                 par_q[g] <= par_init[g];
      else if (run && par_busy[g])   par_q[g] <= par_q[g] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               fl_q <= '0;
    else if (load)                            fl_q <= flash_cyc;
    else if (run && !(|par_busy) && fl_q != '0) fl_q <= fl_q - 1'b1;
  end

  assign done = !(|par_busy) && (fl_q == '0);
endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
  import lpstop_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wfi,
  input  logic             req_wfe,
  input  logic             req_ret,
  input  logic             deep_sleep,
  input  logic             sleep_on_exit,
  input  logic             sev_on_pend,
  input  logic [2:0]       mode_sel,
  input  logic [LINES-1:0] line_pend,
  input  logic [LINES-1:0] line_is_irq,
  input  logic [LINES-1:0] line_vec_en,
  input  logic             periph_flag,
  input  logic             reg_ready,
  input  logic [CNT_W-1:0] osc_wake_cyc,
  input  logic [CNT_W-1:0] reg_wake_cyc,
  input  logic [CNT_W-1:0] flash_wake_cyc,
  output logic             clk_run,
  output logic             lp_reg_sel,
  output logic             core_halt,
  output logic             wake_pulse
);
  lp_state_e state_q, state_d;
  lp_path_e  path_q, path_d;
  logic      deep2_q, deep2_d;
  logic      take;
  lp_kind_e  kind;
  lp_path_e  req_path;
  logic      hit;
  logic      lat_load;
  logic      lat_done;
  logic      pulse_q;

  lpstop_entry #(.LINES(LINES)) entry_i (
    .req_wfi(req_wfi), .req_wfe(req_wfe), .req_ret(req_ret),
    .deep_sleep(deep_sleep), .sleep_on_exit(sleep_on_exit),
    .sev_on_pend(sev_on_pend), .mode_sel(mode_sel),
    .line_pend(line_pend), .periph_flag(periph_flag),
    .take(take), .kind(kind), .path(req_path)
  );

  lpstop_wake #(.LINES(LINES)) wake_i (
    .path(path_q), .line_pend(line_pend), .line_is_irq(line_is_irq),
    .line_vec_en(line_vec_en), .hit(hit)
  );

  lpstop_lat #(.CNT_W(CNT_W)) lat_i (
    .clk(clk), .rst_n(rst_n), .load(lat_load), .run(state_q == ST_WAKE),
    .osc_cyc(osc_wake_cyc), .reg_cyc(reg_wake_cyc), .flash_cyc(flash_wake_cyc),
    .done(lat_done)
  );

  always_comb begin
    state_d  = state_q;
    path_d   = path_q;
    deep2_d  = deep2_q;
    lat_load = 1'b0;
    unique case (state_q)
      ST_RUN: if (take) begin
        path_d  = req_path;
        deep2_d = (kind == KIND_STOP2);
        unique case (kind)
          KIND_STOP1: state_d = ST_STOP;
          KIND_STOP2: state_d = reg_ready ? ST_STOP : ST_WAIT_REG;
          default:    state_d = ST_SLEEP;
        endcase
      end
      ST_SLEEP:    if (hit) state_d = ST_RUN;
      ST_WAIT_REG: begin
        if (hit)            state_d = ST_RUN;
        else if (reg_ready) state_d = ST_STOP;
      end
      ST_STOP: if (hit) begin
        state_d  = ST_WAKE;
        lat_load = 1'b1;
      end
      ST_WAKE: if (lat_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      path_q  <= PATH_INT;
      deep2_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      path_q  <= path_d;
      deep2_q <= deep2_d;
      pulse_q <= (state_q != ST_RUN) && (state_d == ST_RUN);
    end
  end

  assign core_halt  = (state_q != ST_RUN);
  assign clk_run    = !(state_q == ST_STOP || state_q == ST_WAKE);
  assign lp_reg_sel = (state_q == ST_STOP) && deep2_q;
  assign wake_pulse = pulse_q;
endmodule

// File: rtl/lpstop_ctrl_chk.sv
module lpstop_ctrl_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_halt,
  input logic             clk_run,
  input logic             lp_reg_sel,
  input logic             wake_pulse,
  input logic             reg_ready,
  input logic [LINES-1:0] line_pend,
  input logic             periph_flag
);
  // R9
  gated_means_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |-> core_halt);

  // R10
  pulse_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!core_halt && $past(core_halt)));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R5
  lp_reg_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_reg_sel |-> (core_halt && !clk_run));

  // R5
  lp_reg_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_reg_sel) |-> $past(reg_ready));

  // R4
  pending_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && ((|line_pend) || periph_flag)) |=> !core_halt);
endmodule

bind lpstop_ctrl lpstop_ctrl_chk #(.LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .clk_run(clk_run),
  .lp_reg_sel(lp_reg_sel), .wake_pulse(wake_pulse), .reg_ready(reg_ready),
  .line_pend(line_pend), .periph_flag(periph_flag)
);

// File: tb/lpstop_ctrl_tb_top.sv
module lpstop_ctrl_tb_top;
  localparam int LINES = 4;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wfi = 0, req_wfe = 0, req_ret = 0;
  logic deep_sleep = 0, sleep_on_exit = 0, sev_on_pend = 0;
  logic [2:0] mode_sel = 3'b000;
  logic [LINES-1:0] line_pend = '0, line_is_irq = '0, line_vec_en = '0;
  logic periph_flag = 0, reg_ready = 0;
  logic [CNT_W-1:0] osc_wake_cyc = '0, reg_wake_cyc = '0, flash_wake_cyc = '0;
  logic clk_run, lp_reg_sel, core_halt, wake_pulse;

  always #10 clk = ~clk;

  lpstop_ctrl #(.LINES(LINES), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_wfi(req_wfi), .req_wfe(req_wfe), .req_ret(req_ret),
    .deep_sleep(deep_sleep), .sleep_on_exit(sleep_on_exit), .sev_on_pend(sev_on_pend),
    .mode_sel(mode_sel), .line_pend(line_pend), .line_is_irq(line_is_irq),
    .line_vec_en(line_vec_en), .periph_flag(periph_flag), .reg_ready(reg_ready),
    .osc_wake_cyc(osc_wake_cyc), .reg_wake_cyc(reg_wake_cyc), .flash_wake_cyc(flash_wake_cyc),
    .clk_run(clk_run), .lp_reg_sel(lp_reg_sel), .core_halt(core_halt), .wake_pulse(wake_pulse)
  );

  typedef struct {
    string      tag;
    logic [3:0] exp;  // {core_halt, clk_run, lp_reg_sel, wake_pulse}
  } sb_item_t;

  sb_item_t sb_q[$];
  event     smp;
  int       checks = 0;
  int       errors = 0;
  bit       done = 0;

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(smp);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [3:0] act;
        it  = sb_q.pop_front();
        act = {core_halt, clk_run, lp_reg_sel, wake_pulse};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: halt/run/lp/pulse actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(input string tag, input logic [3:0] exp);
    sb_item_t it;
    it.tag = tag;
    it.exp = exp;
    sb_q.push_back(it);
    -> smp;
    #1;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_req(input int which);
    if (which == 0) req_wfi = 1;
    else if (which == 1) req_wfe = 1;
    else req_ret = 1;
    cyc();
    req_wfi = 0; req_wfe = 0; req_ret = 0;
  endtask

  // Wake from a stop state: pending already driven at a negedge
  task automatic stop_wake(input string tag, input int lat);
    for (int i = 0; i < lat; i++) begin
      cyc();
      expect_out(tag, 4'b1000);
      line_pend = '0;
    end
    cyc();
    expect_out(tag, 4'b0101);
    cyc();
    expect_out(tag, 4'b0100);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    // lines: 0 = irq enabled, 1 = irq disabled vector, 2/3 = event
    line_is_irq = 4'b0011;
    line_vec_en = 4'b0001;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    expect_out("R1 reset state", 4'b0100);

    // R3: return-from-handler ignored without sleep_on_exit
    deep_sleep = 1; mode_sel = 3'b001; sleep_on_exit = 0;
    pulse_req(2);
    expect_out("R3 ret ignored", 4'b0100);

    // R4: pending line / peripheral flag blocks entry
    line_pend = 4'b0100;
    pulse_req(0);
    expect_out("R4 line pending", 4'b0100);
    line_pend = '0; periph_flag = 1;
    pulse_req(0);
    expect_out("R4 flag pending", 4'b0100);
    periph_flag = 0;

    // R2/R6: wfi into stop1, only enabled irq line wakes
    osc_wake_cyc = 3; reg_wake_cyc = 1; flash_wake_cyc = 2;
    pulse_req(0);
    expect_out("R2 stop1 entry", 4'b1000);
    line_pend = 4'b0010; cyc();
    expect_out("R6 disabled vector", 4'b1000);
    line_pend = 4'b0100; cyc();
    expect_out("R6 event line", 4'b1000);
    line_pend = 4'b0001;
    stop_wake("R9 R10 osc dominant", 6);

    // R3: return-from-handler with sleep_on_exit enters
    sleep_on_exit = 1;
    pulse_req(2);
    expect_out("R3 ret enters", 4'b1000);
    osc_wake_cyc = 0; reg_wake_cyc = 0; flash_wake_cyc = 0;
    line_pend = 4'b0001;
    stop_wake("R9 zero latency", 1);
    sleep_on_exit = 0;

    // R7: wfe with sev=0, event lines wake
    osc_wake_cyc = 1; reg_wake_cyc = 4; flash_wake_cyc = 0;
    sev_on_pend = 0;
    pulse_req(1);
    expect_out("R7 wfe entry", 4'b1000);
    line_pend = 4'b0001; cyc();
    expect_out("R7 irq line no wake", 4'b1000);
    line_pend = 4'b1000;
    stop_wake("R7 R9 reg dominant", 5);

    // R8/R12: wfe with sev=1, then flip sev while halted
    osc_wake_cyc = 0; reg_wake_cyc = 0; flash_wake_cyc = 0;
    sev_on_pend = 1;
    pulse_req(1);
    expect_out("R8 wfe sev entry", 4'b1000);
    sev_on_pend = 0;
    line_pend = 4'b0100; cyc();
    expect_out("R12 path kept", 4'b1000);
    line_pend = 4'b0010;
    stop_wake("R8 disabled irq wakes", 1);

    // R5: deeper stop waits for regulator
    mode_sel = 3'b010; reg_ready = 0;
    osc_wake_cyc = 2; reg_wake_cyc = 2; flash_wake_cyc = 1;
    pulse_req(0);
    expect_out("R5 waiting", 4'b1100);
    cyc();
    expect_out("R5 still waiting", 4'b1100);
    reg_ready = 1; cyc();
    expect_out("R5 stop2 entered", 4'b1010);
    line_pend = 4'b0001;
    stop_wake("R5 R9 stop2 wake", 4);

    // R5: ready already high, direct entry
    osc_wake_cyc = 0; reg_wake_cyc = 0; flash_wake_cyc = 0;
    pulse_req(0);
    expect_out("R5 direct stop2", 4'b1010);
    line_pend = 4'b0001;
    stop_wake("R5 direct wake", 1);

    // R5: wake while waiting for regulator
    reg_ready = 0;
    pulse_req(0);
    expect_out("R5 wait again", 4'b1100);
    line_pend = 4'b0001; cyc();
    expect_out("R5 abort wait", 4'b0101);
    line_pend = '0; cyc();
    expect_out("R10 pulse ends", 4'b0100);

    // R11: other mode code gives plain sleep
    mode_sel = 3'b100;
    pulse_req(0);
    expect_out("R11 plain sleep", 4'b1100);
    line_pend = 4'b0001; cyc();
    expect_out("R11 sleep wake", 4'b0101);
    line_pend = '0; cyc();
    expect_out("R11 after wake", 4'b0100);

    // R11: deep_sleep clear gives plain sleep
    mode_sel = 3'b001; deep_sleep = 0;
    pulse_req(0);
    expect_out("R11 no deep sleep", 4'b1100);
    line_pend = 4'b0001; cyc();
    expect_out("R11 wake no latency", 4'b0101);
    line_pend = '0; cyc();

    done = 1;
    report();
  end
endmodule